// File: doc/BRIEF.md
# Frame-Aligned Flush and Timing-Enable Controller

This block collects update requests for the subunits of one display output path and releases them all together at a frame boundary. Software marks subunits as needing an update by writing ones into a flush register. At the next vertical sync the block sends every marked subunit a one-cycle latch strobe and clears the register. Software knows the commit is complete when the register reads zero.

The same controller owns the enable of the output's timing engine. An enable or disable request is stored, and it changes the engine's state only at a vertical sync. A turn-on also waits until a configuration flush of the interface subunit has been committed. A vblank interrupt pulse marks each frame boundary crossed while the engine runs.

When two outputs share one control path, single-flush mode lets only the master side post flush bits. Writes from the slave side are dropped.

Top module: `frame_commit_ctl`

## Requirements
- R1: While reset is low and in the first cycle after it, `flushPending`, `latchStrobe`, `engineEn` and `vblankIrq` all read zero.
- R2: A flush write ORs `flushWrMask` into `flushPending`; zero bits in the mask clear nothing. Bit positions: 0 = display interface, 1 = 3D merge stage, 2 = chroma down-sampler, 3 = peripheral packet unit. The new value is visible one cycle after the write.
- R3: On the clock edge where `vsync` is high, `latchStrobe` takes the value `flushPending` had before that edge, for exactly one cycle, and `flushPending` clears. `latchStrobe` is zero in every other cycle.
- R4: A flush write made in the same cycle as `vsync` is not lost. Its bits appear in `flushPending` after that edge and are strobed at the following vsync.
- R5: When `singleFlush` is 1 and `isSlave` is 1, flush writes are ignored. A slave without single-flush mode, or a master in single-flush mode, is honoured as in R2.
- R6: After a disable request (`enableWrData` = 0), `engineEn` stays 1 until the next vsync, and it clears on that edge.
- R7: `engineEn` changes only on a vsync edge. A stored turn-on request takes effect only if an interface flush (bit 0) is committed on that same vsync, or was committed since the engine was last disabled.
- R8: `vblankIrq` pulses for one cycle after each vsync edge at which `engineEn` was 1. This includes the edge that latches a disable, and excludes the edge that latches a turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle frame boundary pulse |
| flushWrEn | input | 1 | Flush register write strobe |
| flushWrMask | input | NUM_UNITS | Bits to set in the flush register |
| singleFlush | input | 1 | Single-flush mode for a shared control path |
| isSlave | input | 1 | This output is the slave of a pair |
| enableWrEn | input | 1 | Timing-engine enable request write strobe |
| enableWrData | input | 1 | Requested engine state |
| flushPending | output | NUM_UNITS | Flush register readback |
| latchStrobe | output | NUM_UNITS | Per-subunit latch strobes |
| engineEn | output | 1 | Latched timing-engine enable status |
| vblankIrq | output | 1 | Vblank interrupt pulse |

## Verification
The flush path is driven with single-bit, multi-bit and all-ones masks under every combination of role and single-flush mode. This separates a correctly gated slave from a gate that drops master writes or drops all writes in single-flush mode. Writes placed in the vsync cycle, both on an empty register and on top of older bits, show whether the clear-on-commit takes priority over the new set. The enable sequence turns the engine on with and without a prior interface flush, disables it, and re-enables it after the disable. This exposes an enable that ignores the frame boundary, an enable that forgets the configuration gate, and an interrupt that misses the final pulse or fires on turn-on.

// File: rtl/frame_commit_pkg.sv
package frame_commit_pkg;
  // Strobes from the control half to the flush datapath
  typedef struct packed {
    logic commit;    // frame boundary: hand pending bits to subunits
    logic acceptWr;  // software flush write is honoured this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/frame_commit_dp.sv
module frame_commit_dp
  import frame_commit_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int IF_BIT    = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [NUM_UNITS-1:0] wrMask,
  output logic [NUM_UNITS-1:0] flushPending,
  output logic [NUM_UNITS-1:0] latchStrobe,
  output logic                 ifCommit
);
  logic [NUM_UNITS-1:0] keepBits;
  logic [NUM_UNITS-1:0] setBits;

  assign keepBits = strb.commit   ? '0 : flushPending;
  assign setBits  = strb.acceptWr ? wrMask : '0;
  assign ifCommit = strb.commit && flushPending[IF_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPending <= '0;
      latchStrobe  <= '0;
    end else begin
      latchStrobe  <= strb.commit ? flushPending : '0;
      flushPending <= keepBits | setBits;
    end
  end

  // R3: strobe carries the register as it stood at the commit edge
  assert_strobe_matches_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> latchStrobe == $past(flushPending));
  // R3: no strobe away from a commit
  assert_strobe_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> latchStrobe == '0);
  // R2: without a commit no pending bit is lost
  assert_bits_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> (flushPending & $past(flushPending)) == $past(flushPending));
endmodule

// File: rtl/frame_commit_ctrl.sv
module frame_commit_ctrl
  import frame_commit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vsync,
  input  logic       flushWrEn,
  input  logic       singleFlush,
  input  logic       isSlave,
  input  logic       enableWrEn,
  input  logic       enableWrData,
  input  logic       ifCommit,
  output ctlStrobe_t strb,
  output logic       engineEn,
  output logic       vblankIrq
);
  logic enReq;
  logic cfgDone;
  logic turnOn;
  logic turnOff;

  assign strb.commit   = vsync;
  assign strb.acceptWr = flushWrEn && !(singleFlush && isSlave);

  assign turnOn  = vsync && enReq && !engineEn && (cfgDone || ifCommit);
  assign turnOff = vsync && !enReq && engineEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReq     <= 1'b0;
      cfgDone   <= 1'b0;
      engineEn  <= 1'b0;
      vblankIrq <= 1'b0;
    end else begin
      if (enableWrEn) enReq <= enableWrData;
      if (turnOff)       cfgDone <= 1'b0;
      else if (ifCommit) cfgDone <= 1'b1;
      if (turnOn)        engineEn <= 1'b1;
      else if (turnOff)  engineEn <= 1'b0;
      vblankIrq <= vsync && engineEn;
    end
  end

  // R5: slave writes never reach the datapath in single-flush mode
  assert_slave_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (singleFlush && isSlave) |-> !strb.acceptWr);
  // R7: engine state moves only on a frame boundary
  assert_en_frame_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    !vsync |=> $stable(engineEn));
  // R7: a turn-on needs a committed interface configuration
  assert_on_needs_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engineEn) |-> $past(cfgDone || ifCommit));
  // R8: interrupt follows a vsync seen while running
  assert_irq_when_running_R8: assert property (@(posedge clk) disable iff (!rstN)
    vblankIrq |-> ($past(vsync) && $past(engineEn)));
endmodule

// File: rtl/frame_commit_ctl.sv
module frame_commit_ctl
  import frame_commit_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int IF_BIT    = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 vsync,
  input  logic                 flushWrEn,
  input  logic [NUM_UNITS-1:0] flushWrMask,
  input  logic                 singleFlush,
  input  logic                 isSlave,
  input  logic                 enableWrEn,
  input  logic                 enableWrData,
  output logic [NUM_UNITS-1:0] flushPending,
  output logic [NUM_UNITS-1:0] latchStrobe,
  output logic                 engineEn,
  output logic                 vblankIrq
);
  ctlStrobe_t strb;
  logic       ifCommit;

  frame_commit_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .vsync(vsync), .flushWrEn(flushWrEn),
    .singleFlush(singleFlush), .isSlave(isSlave),
    .enableWrEn(enableWrEn), .enableWrData(enableWrData),
    .ifCommit(ifCommit), .strb(strb), .engineEn(engineEn), .vblankIrq(vblankIrq)
  );

  frame_commit_dp #(.NUM_UNITS(NUM_UNITS), .IF_BIT(IF_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrMask(flushWrMask),
    .flushPending(flushPending), .latchStrobe(latchStrobe), .ifCommit(ifCommit)
  );
endmodule

// File: tb/tb_frame_commit_ctl.sv
`timescale 1ns/1ps
module tb_frame_commit_ctl;
  localparam int NU = 4;
  logic clk = 1'b0;
  logic rstN, vsync, flushWrEn, singleFlush, isSlave, enableWrEn, enableWrData;
  logic [NU-1:0] flushWrMask, flushPending, latchStrobe;
  logic engineEn, vblankIrq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_commit_ctl #(.NUM_UNITS(NU)) dut (
    .clk(clk), .rstN(rstN), .vsync(vsync), .flushWrEn(flushWrEn),
    .flushWrMask(flushWrMask), .singleFlush(singleFlush), .isSlave(isSlave),
    .enableWrEn(enableWrEn), .enableWrData(enableWrData),
    .flushPending(flushPending), .latchStrobe(latchStrobe),
    .engineEn(engineEn), .vblankIrq(vblankIrq)
  );

  // {singleFlush, isSlave, mask[3:0], expectedPending[3:0]}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 4'b0001, 4'b0001},
    {1'b0, 1'b0, 4'b1110, 4'b1110},
    {1'b0, 1'b1, 4'b1010, 4'b1010},
    {1'b1, 1'b0, 4'b0110, 4'b0110},
    {1'b1, 1'b1, 4'b1111, 4'b0000},
    {1'b0, 1'b0, 4'b1111, 4'b1111}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    vsync = 0; flushWrEn = 0; flushWrMask = '0;
    enableWrEn = 0; enableWrData = 0;
  endtask

  task automatic doReset();
    idle(); singleFlush = 0; isSlave = 0;
    rstN = 0;
    step(); step();
    chk("R1 pending in reset", 8'(flushPending), 8'h0);
    chk("R1 engine in reset", 8'(engineEn), 8'h0);
    rstN = 1;
    step();
    chk("R1 strobe after reset", 8'(latchStrobe), 8'h0);
    chk("R1 irq after reset", 8'(vblankIrq), 8'h0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();

    // Flush register patterns across role and mode (R2, R3, R5)
    for (int i = 0; i < 6; i++) begin
      singleFlush = VEC[i][9]; isSlave = VEC[i][8];
      flushWrEn = 1; flushWrMask = VEC[i][7:4];
      step();
      idle();
      chk("R2/R5 pending after write", 8'(flushPending), 8'(VEC[i][3:0]));
      singleFlush = 0; isSlave = 0;
      vsync = 1;
      step();
      idle();
      chk("R3 strobe at vsync", 8'(latchStrobe), 8'(VEC[i][3:0]));
      chk("R3 pending cleared", 8'(flushPending), 8'h0);
      step();
      chk("R3 strobe one cycle", 8'(latchStrobe), 8'h0);
    end

    // R2: accumulation, zero mask clears nothing
    flushWrEn = 1; flushWrMask = 4'b0001; step();
    flushWrMask = 4'b1000; step();
    flushWrMask = 4'b0000; step();
    idle();
    chk("R2 accumulate", 8'(flushPending), 8'h9);
    vsync = 1; step(); idle();
    chk("R3 strobe accumulated", 8'(latchStrobe), 8'h9);

    // Enable sequencing
    doReset();
    enableWrEn = 1; enableWrData = 1; step(); idle();
    vsync = 1; step(); idle();
    chk("R7 no turn-on without config", 8'(engineEn), 8'h0);
    flushWrEn = 1; flushWrMask = 4'b0001; step(); idle();
    step();
    chk("R7 no turn-on between vsyncs", 8'(engineEn), 8'h0);
    vsync = 1; step(); idle();
    chk("R7 turn-on with interface commit", 8'(engineEn), 8'h1);
    chk("R8 no irq on turn-on edge", 8'(vblankIrq), 8'h0);
    vsync = 1; step(); idle();
    chk("R8 irq while running", 8'(vblankIrq), 8'h1);
    step();
    chk("R8 irq one cycle", 8'(vblankIrq), 8'h0);
    enableWrEn = 1; enableWrData = 0; step(); idle();
    chk("R6 still on after disable write", 8'(engineEn), 8'h1);
    step(); step();
    chk("R6 still on before vsync", 8'(engineEn), 8'h1);
    vsync = 1; step(); idle();
    chk("R6 off at vsync", 8'(engineEn), 8'h0);
    chk("R8 final irq on disable", 8'(vblankIrq), 8'h1);
    vsync = 1; step(); idle();
    chk("R8 no irq when off", 8'(vblankIrq), 8'h0);
    enableWrEn = 1; enableWrData = 1; step(); idle();
    vsync = 1; step(); idle();
    chk("R7 config cleared by disable", 8'(engineEn), 8'h0);

    // R4: write coinciding with vsync
    flushWrEn = 1; flushWrMask = 4'b0100; vsync = 1; step(); idle();
    chk("R4 no strobe from same-cycle write", 8'(latchStrobe), 8'h0);
    chk("R4 bits held over", 8'(flushPending), 8'h4);
    vsync = 1; step(); idle();
    chk("R4 strobe next vsync", 8'(latchStrobe), 8'h4);
    flushWrEn = 1; flushWrMask = 4'b0010; step();
    flushWrMask = 4'b1000; vsync = 1; step(); idle();
    chk("R4 old bits strobed", 8'(latchStrobe), 8'h2);
    chk("R4 new bits kept", 8'(flushPending), 8'h8);
    chk("R7 no interface commit keeps off", 8'(engineEn), 8'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule